// File: doc/BRIEF.md
# Load/Store Byte and Word Unit

This unit sits between the execute stage of a 32-bit RISC core and a single-cycle synchronous data memory. For every memory instruction it forms the effective byte address from a base register value and a 16-bit signed displacement. It drives a byte-enabled SRAM-style port, either reading a word or writing one or more byte lanes.

Stores take effect in the cycle of the request. A load's read data returns from the memory one cycle later. The unit then picks the addressed byte when needed and extends it to 32 bits, and presents the result together with a one-cycle valid strobe that the core uses to write its destination register. Lanes are ordered little-endian: address bits [1:0] equal to n select data bits [8n+7:8n]. Misaligned word accesses raise no trap. A word access ignores the two low address bits when it picks lanes.

Top module: `lsu_unit`

## Requirements
- R1: While `req_valid` is high with a legal operation code, `mem_addr` in the same cycle equals `base_val` plus `offset` sign-extended to 32 bits, with wrap-around modulo 2^32.
- R2: A word load (op code 0) returns the full 32-bit memory word unchanged on `load_data`.
- R3: A signed byte load (op code 1) returns the addressed byte, with bit 7 of that byte copied into bits 31:8.
- R4: An unsigned byte load (op code 2) returns the addressed byte, with bits 31:8 forced to zero.
- R5: A word store (op code 3) raises `mem_we` and sets `mem_be` to 4'b1111, with `mem_wdata` equal to `store_data`.
- R6: A byte store (op code 4) sets only bit n of `mem_be`, where n = `mem_addr[1:0]`, and places `store_data[7:0]` in byte lane n of `mem_wdata`. The other three bytes of that memory word keep their values.
- R7: `load_valid` is high for exactly one cycle, one cycle after each accepted load request. It stays low after stores and idle cycles. `mem_be` is zero on reads.
- R8: While `rst_n` is low and in the first cycle after it, `load_valid` and `mem_en` are low, provided no request is presented.
- R9: Op codes 5 to 7 are ignored. They leave `mem_en` low and produce no `load_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A memory operation is presented this cycle |
| req_op | input | 3 | Operation code: 0 word load, 1 signed byte load, 2 unsigned byte load, 3 word store, 4 byte store |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Byte address to memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write enable (1 = write) |
| mem_be | output | 4 | Byte lane enables, bit n = bits 8n+7:8n |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| load_valid | output | 1 | Load result is valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
The bench loads bytes whose bit 7 is set through both byte-load codes. A design that mixes up sign and zero extension returns 0xFFFFFF80 where 0x00000080 is due, or the reverse. Every lane is read and written, so a design with a reversed lane order or a lane select that is off by one returns or overwrites the wrong byte. A word read after a byte store exposes byte enables that are too wide. A negative displacement shows whether the offset is sign-extended. Back-to-back loads, a load straight after a store, and illegal op codes expose a strobe that is lost, repeated or spurious.

// File: rtl/lsu_pkg.sv
// Package: shared operation codes and helpers for the load/store unit.
// Assumes a 3-bit operation field; codes 5..7 are unused and mean no access.
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_LW  = 3'd0,
        OP_LB  = 3'd1,
        OP_LBU = 3'd2,
        OP_SW  = 3'd3,
        OP_SB  = 3'd4
    } lsu_op_e;

    // True for any of the three read operations.
    function automatic logic op_is_load(input logic [2:0] op);
        return (op == OP_LW) || (op == OP_LB) || (op == OP_LBU);
    endfunction

    // True for either write operation.
    function automatic logic op_is_store(input logic [2:0] op);
        return (op == OP_SW) || (op == OP_SB);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Module: effective address generator.
// Adds a base value to a displacement sign-extended to the address width.
// Assumes OFF_W <= ADDR_W; the sum wraps modulo 2^ADDR_W.
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
        addr_o  = base_i + off_ext;
    end
endmodule

// File: rtl/lsu_store_align.sv
// Module: store lane steering.
// Produces the byte enables and lane-aligned write data for word and byte stores.
// Assumes little-endian lanes; byte stores replicate the low source byte to all lanes.
module lsu_store_align #(
    parameter int DATA_W = 32
) (
    input  logic                        word_i,
    input  logic                        byte_i,
    input  logic [$clog2(DATA_W/8)-1:0] lane_i,
    input  logic [DATA_W-1:0]           src_i,
    output logic [DATA_W/8-1:0]         be_o,
    output logic [DATA_W-1:0]           wdata_o
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Enable lane g for a word store, or for a byte store addressed to it.
        always_comb begin
            be_o[g] = word_i | (byte_i & (lane_i == LANE_W'(g)));
            wdata_o[g*8 +: 8] = word_i ? src_i[g*8 +: 8] : src_i[7:0];
        end
    end
endmodule

// File: rtl/lsu_load_extend.sv
// Module: load result formatter.
// Picks the addressed byte of the read word and sign- or zero-extends it;
// word loads pass the read word through.
// Assumes lane and mode were captured in the request cycle.
module lsu_load_extend #(
    parameter int DATA_W = 32
) (
    input  logic                        word_i,
    input  logic                        signed_i,
    input  logic [$clog2(DATA_W/8)-1:0] lane_i,
    input  logic [DATA_W-1:0]           rdata_i,
    output logic [DATA_W-1:0]           data_o
);
    logic [7:0] sel_byte;

    // Select the lane and extend it as the captured mode requires.
    always_comb begin
        sel_byte = rdata_i[lane_i*8 +: 8];
        if (word_i)
            data_o = rdata_i;
        else if (signed_i)
            data_o = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
        else
            data_o = {{(DATA_W-8){1'b0}}, sel_byte};
    end
endmodule

// File: rtl/lsu_unit.sv
// Module: load/store unit top.
// Drives a single-cycle synchronous memory port and returns extended load
// data with a valid strobe one cycle after each load request.
// Assumes the memory returns read data exactly one cycle after mem_en with
// mem_we low, and that writes land on the clock edge of the request.
module lsu_unit #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [DATA_W-1:0]   base_val,
    input  logic [OFF_W-1:0]    offset,
    input  logic [DATA_W-1:0]   store_data,
    output logic [DATA_W-1:0]   mem_addr,
    output logic                mem_en,
    output logic                mem_we,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                load_valid,
    output logic [DATA_W-1:0]   load_data
);
    import lsu_pkg::*;

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic              is_load;
    logic              is_store;
    logic [LANES-1:0]  st_be;
    logic              ld_word_q;
    logic              ld_signed_q;
    logic [LANE_W-1:0] ld_lane_q;

    lsu_agen #(.ADDR_W(DATA_W), .OFF_W(OFF_W)) u_agen (
        .base_i (base_val),
        .off_i  (offset),
        .addr_o (mem_addr)
    );

    // Decode the request into access kind.
    always_comb begin
        is_load  = req_valid & op_is_load(req_op);
        is_store = req_valid & op_is_store(req_op);
        mem_en   = is_load | is_store;
        mem_we   = is_store;
        mem_be   = is_store ? st_be : '0;
    end

    lsu_store_align #(.DATA_W(DATA_W)) u_store (
        .word_i  (req_op == OP_SW),
        .byte_i  (req_op == OP_SB),
        .lane_i  (mem_addr[LANE_W-1:0]),
        .src_i   (store_data),
        .be_o    (st_be),
        .wdata_o (mem_wdata)
    );

    // Capture load mode and lane for the cycle the read data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid  <= 1'b0;
            ld_word_q   <= 1'b0;
            ld_signed_q <= 1'b0;
            ld_lane_q   <= '0;
        end else begin
            load_valid  <= is_load;
            ld_word_q   <= (req_op == OP_LW);
            ld_signed_q <= (req_op == OP_LB);
            ld_lane_q   <= mem_addr[LANE_W-1:0];
        end
    end

    lsu_load_extend #(.DATA_W(DATA_W)) u_extend (
        .word_i   (ld_word_q),
        .signed_i (ld_signed_q),
        .lane_i   (ld_lane_q),
        .rdata_i  (mem_rdata),
        .data_o   (load_data)
    );

    // Assertions on port behaviour over time.
    AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_is_load(req_op)) |=> load_valid); // R7
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && op_is_load(req_op))) |=> !load_valid); // R7
    AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == '1 || $countones(mem_be) == 1)); // R6
    AST_READ_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (mem_be == '0)); // R7
    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > 3'd4) |-> !mem_en); // R9
    AST_UNSIGNED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LBU) |=> (load_data[DATA_W-1:8] == '0)); // R4
endmodule

// File: tb/test_lsu_unit.sv
// Bench: scoreboard for lsu_unit with a behavioural one-cycle memory.
module test_lsu_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] base_val = '0;
    logic [15:0] offset = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_addr;
    logic        mem_en;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        load_valid;
    logic [31:0] load_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] mem    [WORDS];
    logic [31:0] shadow [WORDS];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_unit i_lsu_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_val(base_val), .offset(offset), .store_data(store_data),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_data(load_data)
    );

    // Behavioural memory: byte-enabled write, one-cycle read.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:2]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: present one request, check port outputs, push expected load data.
    task automatic issue(input logic [2:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] src, input string req);
        logic [31:0] ea;
        logic [7:0]  byt;
        logic [31:0] w;
        ea = base + {{16{off[15]}}, off};
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base_val = base; offset = off; store_data = src;
        #1;
        if (op <= 3'd4) check({req, " R1 addr"}, mem_addr, ea);
        if (op == 3'd3) begin
            check("R5 be", {28'd0, mem_be}, 32'hF);
            check("R5 wdata", mem_wdata, src);
        end
        if (op == 3'd4) begin
            check("R6 be", {28'd0, mem_be}, 32'd1 << ea[1:0]);
            check("R6 lane data", {24'd0, mem_wdata[ea[1:0]*8 +: 8]}, {24'd0, src[7:0]});
        end
        if (op > 3'd4) check("R9 mem_en", {31'd0, mem_en}, 32'd0);
        @(posedge clk);
        #1;
        w = shadow[ea[7:2]];
        byt = w[ea[1:0]*8 +: 8];
        case (op)
            3'd0: begin exp_q.push_back(w); tag_q.push_back({req, " R2"}); end
            3'd1: begin exp_q.push_back({{24{byt[7]}}, byt}); tag_q.push_back({req, " R3"}); end
            3'd2: begin exp_q.push_back({24'd0, byt}); tag_q.push_back({req, " R4"}); end
            3'd3: shadow[ea[7:2]] = src;
            3'd4: shadow[ea[7:2]][ea[1:0]*8 +: 8] = src[7:0];
            default: ;
        endcase
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each strobe against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (load_valid && exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7 stray strobe: actual 1 expected 0");
            end else if (!load_valid && exp_q.size() != 0) begin
                checks++; fails++;
                $display("FAIL R7 missing strobe: actual 0 expected 1");
                void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end else if (load_valid) begin
                check(tag_q.pop_front(), load_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = 32'hA500_0000 ^ (i * 32'h0103_0507);
            shadow[i] = 32'hA500_0000 ^ (i * 32'h0103_0507);
        end
        repeat (3) @(posedge clk);
        #1;
        check("R8 load_valid in reset", {31'd0, load_valid}, 32'd0);
        check("R8 mem_en in reset", {31'd0, mem_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 load_valid after reset", {31'd0, load_valid}, 32'd0);

        // Word store then loads of every lane, mixing sign bits.
        issue(3'd3, 32'h0000_0010, 16'h0000, 32'h80FF_7F01, "sw");
        issue(3'd0, 32'h0000_0010, 16'h0000, 32'h0, "lw");
        issue(3'd1, 32'h0000_0010, 16'h0000, 32'h0, "lb lane0");
        issue(3'd1, 32'h0000_000F, 16'h0002, 32'h0, "lb lane1");
        issue(3'd1, 32'h0000_0012, 16'h0000, 32'h0, "lb lane2 neg");
        issue(3'd1, 32'h0000_0013, 16'h0000, 32'h0, "lb lane3 neg");
        issue(3'd2, 32'h0000_0012, 16'h0000, 32'h0, "lbu lane2");
        issue(3'd2, 32'h0000_0013, 16'h0000, 32'h0, "lbu lane3");
        idle();
        // Negative displacement.
        issue(3'd0, 32'h0000_0080, 16'hFFF0, 32'h0, "lw negoff");
        issue(3'd2, 32'h0000_0080, 16'hFF81, 32'h0, "lbu negoff");
        // Byte stores into each lane of one word, then read the word back.
        issue(3'd4, 32'h0000_0020, 16'h0001, 32'h1234_56AB, "sb lane1");
        issue(3'd0, 32'h0000_0020, 16'h0000, 32'h0, "lw after sb R6");
        issue(3'd4, 32'h0000_0024, 16'h0000, 32'hFFFF_FF11, "sb lane0");
        issue(3'd4, 32'h0000_0024, 16'h0003, 32'h0000_00C3, "sb lane3");
        issue(3'd4, 32'h0000_0026, 16'h0000, 32'h0000_0077, "sb lane2");
        idle();
        issue(3'd0, 32'h0000_0024, 16'h0000, 32'h0, "lw lanes R6");
        issue(3'd1, 32'h0000_0027, 16'h0000, 32'h0, "lb stored neg");
        // Illegal op codes, then an idle gap with stores only.
        issue(3'd5, 32'h0000_0030, 16'h0000, 32'h0, "op5");
        issue(3'd7, 32'h0000_0030, 16'h0000, 32'h0, "op7");
        issue(3'd3, 32'h0000_0030, 16'h0000, 32'hDEAD_BEEF, "sw2");
        idle();
        idle();
        issue(3'd0, 32'h0000_0030, 16'h0000, 32'h0, "lw sw2");
        // Wrap-around address.
        issue(3'd2, 32'hFFFF_FFF0, 16'h0021, 32'h0, "lbu wrap");
        idle();
        repeat (3) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule